// File: doc/BRIEF.md
# Pipelined LMS Adaptive FIR Filter

This block is a streaming adaptive filter for real, signed fixed-point samples. Each accepted cycle carries an observed sample `x_i` and a desired sample `d_i`. The observed stream runs through a transposed-form FIR whose taps are live registers. The filter output is subtracted from the desired value to form an error. The error, scaled by an unsigned step size, nudges every tap toward a smaller mean square error. Typical uses are echo or noise cancellation and identifying an unknown system from its input and output.

The datapath has three register stages. A sample taken in cycle t produces its filtered value, its error and the tap vector after its own update in cycle t+3. Samples accepted in cycles t+1 and t+2 still filter with the tap values that were in place before that update. The step size comes either from the `step_i` port or from a constant parameter. Narrowing casts round toward minus infinity. By default they wrap on overflow, and a parameter makes them saturate instead.

Top module: `lms_adapt_fir`

## Requirements
- R1: While `in_valid` is 0, the values on `x_i`, `d_i`, `adapt` and `step_i` have no effect. No output valid, output value or weight is altered by them.
- R2: A tap update happens only for a sample accepted with `in_valid`=1 and `adapt`=1. A sample accepted with `adapt`=0 leaves the weights unchanged, and so do cycles in which `adapt`=1 but `in_valid`=0.
- R3: `rst` is a synchronous clear. On the cycle after it, `out_valid` is 0 and every tap equals the scalar `W_INIT`. Samples in flight are dropped, and the delay line and FIR partial sums restart from zero.
- R4: `out_valid` is 1 in cycle t+3 exactly when a sample was accepted in cycle t with no reset in cycles t to t+2. Every accepted sample yields exactly one output, in order.
- R5: `y_o` is the transposed-form FIR sum of `x_i` times the current taps. The input is Q1.(DW-1) and the weights are Q1.(WW-1). The sum is shifted right by WW-2 with floor rounding into a DW+1 bit result with DW fractional bits.
- R6: `e_o` = (`d_i` shifted left by one) − `y_o`, as a DW+2 bit value with DW fractional bits, for the same sample.
- R7: Let mu be `step_i`, read as unsigned with MUW fractional bits. The step-error product p is floor(e·mu / 2^(MUW+1)), cast to DW bits with DW-1 fractional bits. Each tap k then becomes cast_WW(w[k] + floor(p·x[n−k] / 2^(2·DW−1−WW))).
- R8: `w_o` packs tap k at bits [k·WW +: WW]. In the output cycle of a sample, `w_o` already holds the taps after that sample's update. Samples accepted 3 or more cycles after it filter with the new taps, and samples accepted 1 or 2 cycles after it filter with the old taps.
- R9: With `SAT`=0 every narrowing cast wraps to two's complement. With `SAT`=1 it clamps to the most positive or most negative code.
- R10: Suppose the desired signal is a fixed FIR of the observed signal, the input is white, and the step size is 0.125. Then after 2500 cycles every tap lies within 300 LSB of the true coefficient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous clear of pipeline, delay line and weights |
| in_valid | input | 1 | Sample pair on `x_i`/`d_i` is taken this cycle |
| adapt | input | 1 | Enables the tap update for the sample taken this cycle |
| x_i | input | DW | Observed sample, signed Q1.(DW-1) |
| d_i | input | DW | Desired sample, signed Q1.(DW-1) |
| step_i | input | MUW | Step size, unsigned, MUW fractional bits (used when `MU_PORT`=1) |
| out_valid | output | 1 | `y_o`, `e_o` and `w_o` belong to a sample |
| y_o | output | DW+1 | Filtered sample, DW fractional bits |
| e_o | output | DW+2 | Error, desired minus filtered, DW fractional bits |
| w_o | output | TAPS·WW | Current tap weights, tap k at [k·WW +: WW] |

## Verification
The first stimulus is white input with the desired signal generated by a known four-tap system while adaptation stays on. This pattern separates a correct gradient sign, a correct tap-to-delay pairing and a correct update delay from near misses. A bit-exact reference tracks it every cycle, and the final taps must match the true system. Gaps with junk on the data pins, and cycles with `adapt` high but no valid, expose a block that gates updates on the wrong condition. A stretch that accepts samples with `adapt` low exposes one that ignores the enable. A reset fired with samples in flight checks the abort and the weight reload. A run of full-scale samples against large initial weights overflows the output, and shows whether the cast wraps or saturates according to `SAT`.

// File: rtl/lms_adapt_fir.sv
module lms_adapt_fir #(
  parameter int TAPS     = 8,
  parameter int DW       = 16,
  parameter int WW       = 16,
  parameter int MUW      = 16,
  parameter bit MU_PORT  = 1'b0,
  parameter int MU_CONST = 655,
  parameter int W_INIT   = 0,
  parameter bit SAT      = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic                   adapt,
  input  logic signed [DW-1:0]   x_i,
  input  logic signed [DW-1:0]   d_i,
  input  logic [MUW-1:0]         step_i,
  output logic                   out_valid,
  output logic signed [DW:0]     y_o,
  output logic signed [DW+1:0]   e_o,
  output logic [TAPS*WW-1:0]     w_o
);

  localparam int LG   = (TAPS > 1) ? $clog2(TAPS) : 1;
  localparam int AW   = DW + WW + LG;
  localparam int YW   = DW + 1;
  localparam int EW   = DW + 2;
  localparam int SH_Y = WW - 2;
  localparam int SH_P = MUW + 1;
  localparam int SH_W = 2 * DW - 1 - WW;

  function automatic logic signed [63:0] fit(input logic signed [63:0] v, input int n);
    logic signed [63:0] hi;
    hi = (64'sd1 <<< (n - 1)) - 64'sd1;
    if (SAT) begin
      if (v > hi) return hi;
      if (v < -hi - 64'sd1) return -hi - 64'sd1;
      return v;
    end
    return (v <<< (64 - n)) >>> (64 - n);
  endfunction

  logic signed [DW-1:0]  xd   [TAPS];
  logic signed [DW-1:0]  xs   [TAPS];
  logic signed [WW-1:0]  w    [TAPS];
  logic signed [WW-1:0]  wn   [TAPS];
  logic signed [AW-1:0]  st   [TAPS];
  logic signed [AW-1:0]  prod [TAPS];

  logic signed [AW-1:0]  y1;
  logic signed [DW-1:0]  d1;
  logic [MUW-1:0]        mu1;
  logic                  v1, u1;
  logic signed [YW-1:0]  y2, yc;
  logic signed [EW-1:0]  e2, ec;
  logic signed [DW-1:0]  p2, pc;
  logic                  v2, u2;

  wire [MUW-1:0] mu_in = MU_PORT ? step_i : MUW'(MU_CONST);

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    assign prod[k] = AW'(x_i * w[k]);
    assign wn[k]   = WW'(fit(64'(w[k]) + ((64'(p2) * 64'(xs[k])) >>> SH_W), WW));
    assign w_o[k*WW +: WW] = w[k];
  end

  assign yc = YW'(fit(64'(y1) >>> SH_Y, YW));
  assign ec = (EW'(d1) <<< 1) - EW'(yc);
  assign pc = DW'(fit((64'(ec) * $signed(64'({1'b0, mu1}))) >>> SH_P, DW));

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; u1 <= 1'b0; v2 <= 1'b0; u2 <= 1'b0; out_valid <= 1'b0;
      y1 <= '0; d1 <= '0; mu1 <= '0;
      y2 <= '0; e2 <= '0; p2 <= '0;
      y_o <= '0; e_o <= '0;
      for (int k = 0; k < TAPS; k++) begin
        xd[k] <= '0;
        xs[k] <= '0;
        st[k] <= '0;
        w[k]  <= WW'(W_INIT);
      end
    end else begin
      v1 <= in_valid;
      u1 <= in_valid && adapt;
      v2 <= v1;
      u2 <= u1;
      out_valid <= v2;
      if (in_valid) begin
        y1  <= prod[0] + st[0];
        d1  <= d_i;
        mu1 <= mu_in;
        xd[0] <= x_i;
        for (int k = 1; k < TAPS; k++) xd[k] <= xd[k-1];
        for (int k = 0; k < TAPS - 1; k++) st[k] <= prod[k+1] + st[k+1];
      end
      if (v1) begin
        y2 <= yc;
        e2 <= ec;
        p2 <= pc;
        for (int k = 0; k < TAPS; k++) xs[k] <= xd[k];
      end
      if (v2) begin
        y_o <= y2;
        e_o <= e2;
      end
      if (u2)
        for (int k = 0; k < TAPS; k++) w[k] <= wn[k];
    end
  end

endmodule

// File: rtl/lms_adapt_fir_chk.sv
module lms_adapt_fir_chk #(
  parameter int TAPS   = 8,
  parameter int DW     = 16,
  parameter int WW     = 16,
  parameter int W_INIT = 0
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 adapt,
  input logic signed [DW-1:0] d_i,
  input logic                 out_valid,
  input logic signed [DW:0]   y_o,
  input logic signed [DW+1:0] e_o,
  input logic [TAPS*WW-1:0]   w_o
);
  localparam int EW = DW + 2;
  localparam logic [TAPS*WW-1:0] W_ALL = {TAPS{WW'(W_INIT)}};

  assert_valid_delay_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 3));

  assert_err_diff_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (e_o == ((EW'($past(d_i, 3)) <<< 1) - EW'(y_o))));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    ((w_o != $past(w_o)) && !$past(rst)) |-> $past(in_valid && adapt, 3));

  assert_reload_R3: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && (w_o == W_ALL)));
endmodule

bind lms_adapt_fir lms_adapt_fir_chk #(
  .TAPS(TAPS), .DW(DW), .WW(WW), .W_INIT(W_INIT)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .adapt(adapt), .d_i(d_i),
  .out_valid(out_valid), .y_o(y_o), .e_o(e_o), .w_o(w_o)
);

// File: tb/sim_lms_adapt_fir.sv
module sim_lms_adapt_fir;
  localparam int TAPS = 8, DW = 16, WW = 16, MUW = 16, WI = 16384;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, in_valid = 1'b0, adapt = 1'b0;
  logic signed [DW-1:0] x_i = '0, d_i = '0;
  logic [MUW-1:0] step_i = '0;
  logic out_valid, ov_s;
  logic signed [DW:0] y_o, y_s;
  logic signed [DW+1:0] e_o, e_s;
  logic [TAPS*WW-1:0] w_o, w_s;

  lms_adapt_fir #(.TAPS(TAPS), .DW(DW), .WW(WW), .MUW(MUW), .MU_PORT(1'b1),
                  .W_INIT(WI), .SAT(1'b0)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .adapt(adapt), .x_i(x_i), .d_i(d_i),
    .step_i(step_i), .out_valid(out_valid), .y_o(y_o), .e_o(e_o), .w_o(w_o));

  lms_adapt_fir #(.TAPS(TAPS), .DW(DW), .WW(WW), .MUW(MUW), .MU_PORT(1'b1),
                  .W_INIT(WI), .SAT(1'b1)) u1 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .adapt(adapt), .x_i(x_i), .d_i(d_i),
    .step_i(step_i), .out_valid(ov_s), .y_o(y_s), .e_o(e_s), .w_o(w_s));

  typedef struct packed {
    int due; longint y; longint e; logic [TAPS*64-1:0] dl; bit upd; bit probe;
  } pend_t;
  typedef struct packed {
    int due; longint y; longint e; logic [TAPS*WW-1:0] w; bit probe;
  } exp_t;

  pend_t  pq[$];
  exp_t   eq[$];
  longint mw[TAPS], ms[TAPS], mx[TAPS], hx[TAPS];
  longint h[TAPS] = '{16384, -8192, 4096, 2048, 0, 0, 0, 0};
  int cyc = 0, checks = 0, errors = 0;

  function automatic longint fitb(longint v, int n);
    longint sh = 64 - n;
    return (v <<< sh) >>> sh;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < TAPS; k++) begin mw[k] = WI; ms[k] = 0; mx[k] = 0; end
    pq.delete();
    eq.delete();
  endtask

  task automatic tick(bit r, bit v, bit a, longint x, longint d, longint mu, bit probe);
    @(negedge clk);
    rst = r; in_valid = v; adapt = a;
    x_i = DW'(x); d_i = DW'(d); step_i = MUW'(mu);
    cyc++;
    if (r) model_reset();
    else begin
      if (v) begin
        pend_t p;
        longint acc, yy, ee, pp;
        acc = x * mw[0] + ms[0];
        for (int k = 0; k < TAPS - 1; k++) ms[k] = x * mw[k+1] + ms[k+1];
        ms[TAPS-1] = 0;
        for (int k = TAPS - 1; k > 0; k--) mx[k] = mx[k-1];
        mx[0] = x;
        yy = fitb(acc >>> (WW - 2), DW + 1);
        ee = (d <<< 1) - yy;
        pp = fitb((ee * mu) >>> (MUW + 1), DW);
        p.due = cyc + 2; p.y = yy; p.e = ee; p.upd = a; p.probe = probe;
        for (int k = 0; k < TAPS; k++) p.dl[k*64 +: 64] = (pp * mx[k]) >>> (2*DW - 1 - WW);
        pq.push_back(p);
      end
      if (pq.size() > 0 && pq[0].due == cyc) begin
        pend_t p;
        exp_t  ex;
        p = pq.pop_front();
        if (p.upd)
          for (int k = 0; k < TAPS; k++) mw[k] = fitb(mw[k] + $signed(p.dl[k*64 +: 64]), WW);
        ex.due = cyc; ex.y = p.y; ex.e = p.e; ex.probe = p.probe;
        for (int k = 0; k < TAPS; k++) ex.w[k*WW +: WW] = WW'(mw[k]);
        eq.push_back(ex);
      end
    end
  endtask

  function automatic longint rnd(int amp);
    return longint'($urandom_range(0, 2*amp)) - amp;
  endfunction

  // scoreboard monitor: pops expected items in the output cycle (R4, R5, R6, R7, R8, R9)
  initial forever begin
    @(posedge clk);
    #1;
    if (out_valid) begin
      if (eq.size() == 0 || eq[0].due != cyc)
        chk(1'b0, "R4", "unexpected out_valid in cycle", cyc, (eq.size() > 0) ? eq[0].due : -1);
      else begin
        exp_t ex;
        int bad;
        ex = eq.pop_front();
        chk(y_o == ex.y, "R5", "filtered y", y_o, ex.y);
        chk(e_o == ex.e, "R6", "error e", e_o, ex.e);
        bad = -1;
        for (int k = TAPS - 1; k >= 0; k--) if (w_o[k*WW +: WW] != ex.w[k*WW +: WW]) bad = k;
        chk(bad < 0, "R7 R8", "first mismatching tap weight",
            (bad < 0) ? 0 : longint'($signed(w_o[bad*WW +: WW])),
            (bad < 0) ? 0 : longint'($signed(ex.w[bad*WW +: WW])));
        if (ex.probe) begin
          chk(y_o == -8, "R9", "wrapped y (SAT=0)", y_o, -8);
          chk(y_s == 65535, "R9", "saturated y (SAT=1)", y_s, 65535);
        end
      end
    end else if (eq.size() > 0 && eq[0].due == cyc) begin
      chk(1'b0, "R4", "missing out_valid in cycle", cyc, eq[0].due);
      void'(eq.pop_front());
    end
  end

  initial begin
    #(4 * 200000);
    chk(1'b0, "R4", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [TAPS*WW-1:0] wsave;
    model_reset();
    repeat (3) tick(1, 0, 0, 0, 0, 0, 0);
    tick(0, 0, 0, 0, 0, 0, 0);
    // R3: reset state
    chk(out_valid == 1'b0, "R3", "out_valid after reset", out_valid, 0);
    chk(y_o == 0, "R3", "y after reset", y_o, 0);
    for (int k = 0; k < TAPS; k++)
      chk($signed(w_o[k*WW +: WW]) == WI, "R3", "initial weight", $signed(w_o[k*WW +: WW]), WI);

    // R10 convergence toward a known system; invalid cycles carry junk (R1)
    for (int k = 0; k < TAPS; k++) hx[k] = 0;
    for (int i = 0; i < 2500; i++) begin
      bit v;
      longint x, dd;
      v = ($urandom_range(0, 4) != 0);
      x = rnd(16383);
      if (v) begin
        for (int k = TAPS - 1; k > 0; k--) hx[k] = hx[k-1];
        hx[0] = x;
        dd = 0;
        for (int k = 0; k < TAPS; k++) dd += h[k] * hx[k];
        dd = dd >>> 15;
        tick(0, 1, 1, x, dd, 8192, 0);
      end else
        tick(0, 0, 1, rnd(32767), rnd(32767), $urandom_range(0, 65535), 0);
    end
    repeat (6) tick(0, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < TAPS; k++) begin
      longint wk, dv;
      wk = $signed(w_o[k*WW +: WW]);
      dv = (wk > h[k]) ? wk - h[k] : h[k] - wk;
      chk(dv <= 300, "R10", "tap distance from true coefficient", dv, 300);
    end

    // R1: adapt high but valid low, junk on data pins
    wsave = w_o;
    repeat (12) tick(0, 0, 1, rnd(32767), rnd(32767), 65535, 0);
    chk(w_o == wsave, "R1", "weights changed with valid low", $signed(w_o[WW-1:0]), $signed(wsave[WW-1:0]));
    chk(out_valid == 1'b0, "R1", "out_valid with valid low", out_valid, 0);

    // R2: samples accepted with adapt low
    for (int i = 0; i < 60; i++) begin
      bit v;
      v = $urandom_range(0, 1);
      tick(0, v, !v, rnd(16383), rnd(16383), 8192, 0);
    end
    repeat (6) tick(0, 0, 0, 0, 0, 0, 0);
    chk(w_o == wsave, "R2", "weights changed with adapt low", $signed(w_o[WW-1:0]), $signed(wsave[WW-1:0]));

    // R3: reset with samples in flight
    for (int i = 0; i < 20; i++) tick(0, 1, 1, rnd(16383), rnd(16383), 16384, 0);
    repeat (2) tick(1, 1, 1, rnd(16383), rnd(16383), 16384, 0);
    tick(0, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < TAPS; k++)
      chk($signed(w_o[k*WW +: WW]) == WI, "R3", "weight reload after abort", $signed(w_o[k*WW +: WW]), WI);
    repeat (4) tick(0, 0, 0, 0, 0, 0, 0);

    // R9: full-scale input against initial weights overflows y
    for (int i = 0; i < TAPS; i++) tick(0, 1, 0, 32767, 0, 0, i == TAPS - 1);
    repeat (5) tick(0, 0, 0, 0, 0, 0, 0);

    // R7: unrelated desired signal, varying step size, back-to-back samples
    tick(1, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 300; i++)
      tick(0, $urandom_range(0, 3) != 0, 1, rnd(20000), rnd(20000), $urandom_range(0, 32767), 0);
    repeat (6) tick(0, 0, 0, 0, 0, 0, 0);

    chk(eq.size() == 0 && pq.size() == 0, "R4", "outputs still outstanding", eq.size() + pq.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule